// File: doc/BRIEF.md
# Integer ALU with Operation Decoder

This block is the combinational execute-stage arithmetic unit of a 32-bit integer pipeline. It comes with the decoder that drives it. A two-bit operation class from the main controller selects the kind of work: memory address generation, a branch test, a register or immediate operation, or a jump. The decoder combines that class with the instruction's funct3 and funct7 fields and produces a 5-bit internal operation code. It brings that code out on a port.

The datapath applies the code to two operands. It returns a result word and a flag that is high when the result is all zeros. Every branch condition is handled as a compare operation. The compare answer sits in bit 0 of the result, and the upper bits are zero. The downstream branch logic therefore only needs to look at bit 0. No register, clock or reset is inside the block.

Top module: `exec_alu`

## Requirements
- R1: Class 2'b00 gives code 00000 and a result of a+b. Class 2'b11 gives code 01011 and a result of 1.
- R2: Class 2'b01 decodes funct3 as follows: 000 gives 00101 (equal), 001 gives 00110 (not equal), 100 gives 00111 (signed less), 101 gives 01000 (signed greater-or-equal), 110 gives 01001 (unsigned less) and 111 gives 01010 (unsigned greater-or-equal). Funct3 010 and 011 give 00000 and a result of a+b.
- R3: Class 2'b10 decodes funct3 as follows: 000 gives 00000 (add), or 00001 (subtract) when funct7 is 7'b0100000. 100 gives 01100 (xor), 110 gives 00010 (or), 111 gives 00011 (and), 010 gives 00100 (signed set-less) and 001 gives 01101 (left shift). Funct3 011 gives 01110 (unsigned set-less). With funct3 values other than 000 and 101, funct7 has no effect.
- R4: Class 2'b10 with funct3 101 gives 01111 (arithmetic right shift) when funct7 is 7'b0100000. Any other funct7 gives 10000 (logical right shift).
- R5: Add and subtract wrap modulo 2^32. And, or and xor act bitwise.
- R6: Signed set-less returns 1 exactly when a is less than b as two's-complement numbers, and 0 otherwise.
- R7: Unsigned set-less, unsigned-less branch and unsigned greater-or-equal branch compare both operands as values in 0 to 2^32-1.
- R8: Each branch code returns 1 when its condition holds and 0 when it does not, with bits 31..1 at zero.
- R9: Every shift uses only bits 4..0 of b as the shift amount. Left and logical right shifts fill with zeros. Arithmetic right shift fills with bit 31 of a.
- R10: zero is high exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_class | input | 2 | Operation class from the main controller |
| funct3 | input | 3 | Instruction funct3 field |
| funct7 | input | 7 | Instruction funct7 field |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, or the immediate |
| op_code | output | 5 | Decoded internal operation code |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench builds the block at its default width of 32. At that width the sign boundary at 0x80000000 and the wrap at 0xFFFFFFFF can be driven directly, and the shift amount field is exactly five bits. Operands such as 0x21 therefore check that bit 5 of b is ignored. Every class, funct3 value and three funct7 patterns are crossed with a set of edge operands. This reaches every code, including both fallbacks in the branch class.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [1:0] {
        CLS_MEM = 2'b00,
        CLS_BR  = 2'b01,
        CLS_REG = 2'b10,
        CLS_JMP = 2'b11
    } op_class_e;

    typedef enum logic [4:0] {
        OP_ADD  = 5'b00000,
        OP_SUB  = 5'b00001,
        OP_OR   = 5'b00010,
        OP_AND  = 5'b00011,
        OP_SLT  = 5'b00100,
        OP_BEQ  = 5'b00101,
        OP_BNE  = 5'b00110,
        OP_BLT  = 5'b00111,
        OP_BGE  = 5'b01000,
        OP_BLTU = 5'b01001,
        OP_BGEU = 5'b01010,
        OP_JAL  = 5'b01011,
        OP_XOR  = 5'b01100,
        OP_SLL  = 5'b01101,
        OP_SLTU = 5'b01110,
        OP_SRA  = 5'b01111,
        OP_SRL  = 5'b10000
    } alu_op_e;

    localparam logic [6:0] F7_ALT = 7'b0100000;

    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_flags_t;

    function automatic logic op_is_branch(alu_op_e op);
        return (op == OP_BEQ) || (op == OP_BNE) || (op == OP_BLT) ||
               (op == OP_BGE) || (op == OP_BLTU) || (op == OP_BGEU);
    endfunction

endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_pkg::*;
(
    input  logic [1:0] op_class,
    input  logic [2:0] funct3,
    input  logic [6:0] funct7,
    output alu_op_e    op
);

    logic alt;
    assign alt = (funct7 == F7_ALT);

    always_comb begin
        op = OP_ADD;
        case (op_class_e'(op_class))
            CLS_MEM: op = OP_ADD;
            CLS_JMP: op = OP_JAL;
            CLS_BR: begin
                case (funct3)
                    3'b000:  op = OP_BEQ;
                    3'b001:  op = OP_BNE;
                    3'b100:  op = OP_BLT;
                    3'b101:  op = OP_BGE;
                    3'b110:  op = OP_BLTU;
                    3'b111:  op = OP_BGEU;
                    default: op = OP_ADD;
                endcase
            end
            CLS_REG: begin
                case (funct3)
                    3'b000:  op = alt ? OP_SUB : OP_ADD;
                    3'b001:  op = OP_SLL;
                    3'b010:  op = OP_SLT;
                    3'b011:  op = OP_SLTU;
                    3'b100:  op = OP_XOR;
                    3'b101:  op = alt ? OP_SRA : OP_SRL;
                    3'b110:  op = OP_OR;
                    default: op = OP_AND;
                endcase
            end
            default: op = OP_ADD;
        endcase
    end

    always_comb begin
        // R2
        br_class_range_chk: assert (op_class != 2'b01 || op_is_branch(op) || op == OP_ADD)
            else $error("branch class produced a non-branch code");
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0]         a,
    input  logic [$clog2(WIDTH)-1:0] shamt,
    input  logic                     left,
    input  logic                     arith,
    output logic [WIDTH-1:0]         y
);

    localparam int SHW = $clog2(WIDTH);

    logic             fill;
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] stg [0:SHW];

    assign fill = arith & ~left & a[WIDTH-1];

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign src[i] = left ? a[WIDTH-1-i] : a[i];
        assign y[i]   = left ? stg[SHW][WIDTH-1-i] : stg[SHW][i];
    end

    assign stg[0] = src;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stg[s+1] = shamt[s] ? {{STEP{fill}}, stg[s][WIDTH-1:STEP]} : stg[s];
    end

    always_comb begin
        if (shamt == '0) begin
            // R9
            no_shift_pass_chk: assert (y == a)
                else $error("zero shift altered the operand");
        end
    end

endmodule

// File: rtl/alu_compare.sv
module alu_compare
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output cmp_flags_t       flags
);

    logic lt_u;
    assign lt_u = (a < b);

    always_comb begin
        flags.eq   = (a == b);
        flags.lt_u = lt_u;
        flags.lt_s = (a[WIDTH-1] != b[WIDTH-1]) ? a[WIDTH-1] : lt_u;
    end

    always_comb begin
        // R7
        ltu_excl_eq_chk: assert (!(flags.lt_u && flags.eq))
            else $error("unsigned less and equal both set");
        // R6
        neg_below_pos_chk: assert (!(a[WIDTH-1] && !b[WIDTH-1]) || flags.lt_s)
            else $error("negative operand not below positive one");
    end

endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op_class,
    input  logic [2:0]       funct3,
    input  logic [6:0]       funct7,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [4:0]       op_code,
    output logic [WIDTH-1:0] result,
    output logic             zero
);

    localparam int SHW = $clog2(WIDTH);

    alu_op_e          op;
    cmp_flags_t       flags;
    logic [WIDTH-1:0] shift_out;
    logic [WIDTH-1:0] sum;
    logic             do_sub;

    alu_op_decoder u_dec (
        .op_class (op_class),
        .funct3   (funct3),
        .funct7   (funct7),
        .op       (op)
    );

    alu_compare #(.WIDTH(WIDTH)) u_cmp (
        .a     (opnd_a),
        .b     (opnd_b),
        .flags (flags)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shf (
        .a     (opnd_a),
        .shamt (opnd_b[SHW-1:0]),
        .left  (op == OP_SLL),
        .arith (op == OP_SRA),
        .y     (shift_out)
    );

    assign do_sub = (op == OP_SUB);
    assign sum    = opnd_a + (do_sub ? ~opnd_b : opnd_b) + WIDTH'(do_sub);

    function automatic logic [WIDTH-1:0] bit0(input logic v);
        return {{(WIDTH-1){1'b0}}, v};
    endfunction

    always_comb begin
        case (op)
            OP_ADD, OP_SUB:          result = sum;
            OP_OR:                   result = opnd_a | opnd_b;
            OP_AND:                  result = opnd_a & opnd_b;
            OP_XOR:                  result = opnd_a ^ opnd_b;
            OP_SLT, OP_BLT:          result = bit0(flags.lt_s);
            OP_BGE:                  result = bit0(~flags.lt_s);
            OP_SLTU, OP_BLTU:        result = bit0(flags.lt_u);
            OP_BGEU:                 result = bit0(~flags.lt_u);
            OP_BEQ:                  result = bit0(flags.eq);
            OP_BNE:                  result = bit0(~flags.eq);
            OP_JAL:                  result = bit0(1'b1);
            OP_SLL, OP_SRL, OP_SRA:  result = shift_out;
            default:                 result = '0;
        endcase
    end

    assign zero    = ~|result;
    assign op_code = op;

    always_comb begin
        if (op_is_branch(op)) begin
            // R8
            branch_bit0_chk: assert (result[WIDTH-1:1] == '0)
                else $error("branch compare set upper result bits");
        end
        if (op == OP_SUB && opnd_a == opnd_b) begin
            // R10
            sub_equal_zero_chk: assert (zero)
                else $error("equal operands subtracted without zero flag");
        end
    end

endmodule

// File: tb/exec_alu_tb_top.sv
module exec_alu_tb_top;

    logic        clk = 1'b0;
    logic [1:0]  op_class = '0;
    logic [2:0]  funct3 = '0;
    logic [6:0]  funct7 = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  op_code;
    logic [31:0] result;
    logic        zero;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    exec_alu dut_i (
        .op_class (op_class),
        .funct3   (funct3),
        .funct7   (funct7),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .op_code  (op_code),
        .result   (result),
        .zero     (zero)
    );

    logic [31:0] vals [7] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000,
                              32'h7FFF_FFFF, 32'h0000_0021, 32'h1234_5F1F};
    logic [6:0]  f7s  [3] = '{7'b0000000, 7'b0100000, 7'b0000001};

    logic [4:0]  exp_code;
    logic [31:0] exp_res;
    string       code_tag;
    string       res_tag;

    task automatic model(input logic [1:0] c, input logic [2:0] f3, input logic [6:0] f7,
                         input logic [31:0] a, input logic [31:0] b);
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint ua = longint'(a);
        longint ub = longint'(b);
        int     sh = int'(b % 32);
        bit     alt = (f7 == 7'd32);
        if (c == 2'd0) begin
            exp_code = 5'd0; exp_res = a + b; code_tag = "R1"; res_tag = "R1";
        end else if (c == 2'd3) begin
            exp_code = 5'd11; exp_res = 32'd1; code_tag = "R1"; res_tag = "R1";
        end else if (c == 2'd1) begin
            code_tag = "R2"; res_tag = "R8";
            case (f3)
                3'd0: begin exp_code = 5'd5;  exp_res = 32'(a == b); end
                3'd1: begin exp_code = 5'd6;  exp_res = 32'(a != b); end
                3'd4: begin exp_code = 5'd7;  exp_res = 32'(sa < sb); end
                3'd5: begin exp_code = 5'd8;  exp_res = 32'(sa >= sb); end
                3'd6: begin exp_code = 5'd9;  exp_res = 32'(ua < ub); res_tag = "R7"; end
                3'd7: begin exp_code = 5'd10; exp_res = 32'(ua >= ub); res_tag = "R7"; end
                default: begin exp_code = 5'd0; exp_res = a + b; res_tag = "R2"; end
            endcase
        end else begin
            code_tag = "R3"; res_tag = "R5";
            case (f3)
                3'd0: begin exp_code = alt ? 5'd1 : 5'd0; exp_res = alt ? a - b : a + b; end
                3'd1: begin exp_code = 5'd13; exp_res = a << sh; res_tag = "R9"; end
                3'd2: begin exp_code = 5'd4;  exp_res = 32'(sa < sb); res_tag = "R6"; end
                3'd3: begin exp_code = 5'd14; exp_res = 32'(ua < ub); res_tag = "R7"; end
                3'd4: begin exp_code = 5'd12; exp_res = a ^ b; end
                3'd5: begin
                    code_tag = "R4"; res_tag = "R9";
                    exp_code = alt ? 5'd15 : 5'd16;
                    exp_res  = alt ? 32'($signed(a) >>> sh) : a >> sh;
                end
                3'd6: begin exp_code = 5'd2; exp_res = a | b; end
                default: begin exp_code = 5'd3; exp_res = a & b; end
            endcase
        end
    endtask

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (class %0d f3 %0d f7 %h a %h b %h)",
                     tag, what, act, exp, op_class, funct3, funct7, opnd_a, opnd_b);
        end
    endtask

    task automatic apply(input logic [1:0] c, input logic [2:0] f3, input logic [6:0] f7,
                         input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_class = c; funct3 = f3; funct7 = f7; opnd_a = a; opnd_b = b;
        model(c, f3, f7, a, b);
        @(posedge clk);
        #2;
        check(code_tag, "op_code", 32'(op_code), 32'(exp_code));
        check(res_tag, "result", result, exp_res);
        check("R10", "zero", 32'(zero), 32'(exp_res == 32'd0));
    endtask

    initial begin
        @(posedge clk);
        #2;
        // R1: idle inputs give add of zeros with zero flag set
        check("R1", "initial op_code", 32'(op_code), 32'd0);
        check("R10", "initial zero", 32'(zero), 32'd1);
        for (int c = 0; c < 4; c++)
            for (int f3 = 0; f3 < 8; f3++)
                for (int k = 0; k < 3; k++)
                    for (int i = 0; i < 7; i++)
                        for (int j = 0; j < 7; j++)
                            apply(2'(c), 3'(f3), f7s[k], vals[i], vals[j]);
        // R9: shift amount 32 and 63 reduce to 0 and 31
        apply(2'd2, 3'd5, 7'd32, 32'h8000_0000, 32'd63);
        apply(2'd2, 3'd1, 7'd0, 32'h0000_00F0, 32'd32);
        // R5: wrap on add and subtract
        apply(2'd2, 3'd0, 7'd0, 32'hFFFF_FFFF, 32'd2);
        apply(2'd2, 3'd0, 7'd32, 32'd0, 32'd1);
        done = 1;
    end

    initial begin
        for (int cyc = 0; cyc < 150000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule